// File: doc/BRIEF.md
# Trigger-Started Functional Unit Socket

This block places a small arithmetic unit behind a register socket on a move-style transport bus. The bus reaches the socket through one write port and one read port. It moves a first value into the operand slot. It then moves a second value into the trigger slot, and that write is what starts the unit. No opcode is involved. The operand value in force at the moment of the trigger write is copied together with the trigger value. A fixed number of cycles later, set by a parameter for each unit, the sum of the two values lands in the result slot, where the bus can read it.

A three-state machine tracks the unit:

- `ST_EMPTY`: reset state. No result exists yet.
- `ST_RUN`: an operation is counting down.
- `ST_HOLD`: a result is held and valid.

The transitions are:

- `GO` (trigger write): from any state into `ST_RUN`.
- `RESTART` (trigger write while in `ST_RUN`): stays in `ST_RUN` and reloads the countdown.
- `TICK`: stays in `ST_RUN` while the count is not zero.
- `FINISH`: from `ST_RUN` into `ST_HOLD` when the count is zero, loading the result slot.

Top module: `fu_socket`

## Requirements
- R1: After reset, `busy` and `result_valid` are 0, and every read address returns 0.
- R2: Write address 0 loads the operand slot. Write address 1 loads the trigger slot. Read addresses 0, 1 and 2 return the operand, trigger and result slots. Read address 3 returns `result_valid` in bit 1, `busy` in bit 0, and zeros above.
- R3: A trigger write raises `busy` on the following cycle.
- R4: A trigger write at clock edge k updates the result slot at edge k+LATENCY. At that same edge `busy` falls and `result_valid` rises.
- R5: The result is the operand captured at trigger time plus the trigger value, modulo 2^WIDTH.
- R6: An operand write made after a trigger write does not change the result of that operation.
- R7: A trigger write clears `result_valid` on the following cycle.
- R8: A trigger write while `busy` restarts the operation. Timing and values follow the newest trigger write only.
- R9: Writes to addresses 2 and 3 change nothing.
- R10: The result slot reads 0 until the first operation completes.
- R11: `busy` and `result_valid` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Write slot address |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 2 | Read slot address |
| rd_data | output | WIDTH | Read data, combinational from the slots |
| busy | output | 1 | Operation in progress |
| result_valid | output | 1 | Result slot holds a completed result |

## Verification
Random streams mix operand writes, trigger writes, writes to read-only addresses, idle gaps and reads from all four addresses. These are scored every cycle against a bench model of the countdown, which shows whether the latency, the capture point and the status flags agree. Directed cases follow:

- Triggers spaced closer than the latency separate restart from queued behaviour.
- An operand write placed right after a trigger separates capture-at-trigger from late sampling.
- A carry-out sum checks the wrap.
- A read of the result slot before any completion checks the zero reset value.

// File: rtl/fu_socket_pkg.sv
package fu_socket_pkg;
    typedef enum logic [1:0] {
        SLOT_OPND = 2'd0,
        SLOT_TRIG = 2'd1,
        SLOT_RSLT = 2'd2,
        SLOT_STAT = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD  = 2'd2
    } fu_state_e;
endpackage

// File: rtl/fu_adder.sv
module fu_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] sum_out
);
    always_comb begin
        sum_out = a_in + b_in;
    end
endmodule

// File: rtl/fu_sequencer.sv
module fu_sequencer #(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic result_valid,
    output logic load_result
);
    import fu_socket_pkg::*;

    localparam int CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(LATENCY - 1);

    fu_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_EMPTY, ST_HOLD: begin
                if (start) begin
                    state_d = ST_RUN;
                    cnt_d   = LOAD_VAL;
                end
            end
            ST_RUN: begin
                if (start) begin
                    cnt_d = LOAD_VAL;
                end else if (cnt_q == '0) begin
                    state_d = ST_HOLD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy         = (state_q == ST_RUN);
        result_valid = (state_q == ST_HOLD);
        load_result  = (state_q == ST_RUN) && !start && (cnt_q == '0);
    end

    // Independent age counter used to check the latency window.
    logic [CW:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (start) begin
            age_q <= '0;
        end else if (busy) begin
            age_q <= age_q + 1'b1;
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R3
    AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !result_valid); // R7
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && result_valid)); // R11
    AST_LAT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_result |-> (age_q == (CW+1)'(LATENCY - 1))); // R4
    AST_VALID_ROSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> $past(load_result)); // R4
endmodule

// File: rtl/fu_slots.sv
module fu_slots #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    input  logic             load_result,
    input  logic [WIDTH-1:0] unit_result,
    input  logic             busy,
    input  logic             result_valid,
    output logic             start,
    output logic [WIDTH-1:0] snap_opnd,
    output logic [WIDTH-1:0] trig_val,
    output logic [WIDTH-1:0] rd_data
);
    import fu_socket_pkg::*;

    logic [WIDTH-1:0] opnd_q, trig_q, snap_q, rslt_q;
    logic             opnd_wr;

    always_comb begin
        opnd_wr = wr_en && (slot_e'(wr_addr) == SLOT_OPND);
        start   = wr_en && (slot_e'(wr_addr) == SLOT_TRIG);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q <= '0;
            trig_q <= '0;
            snap_q <= '0;
            rslt_q <= '0;
        end else begin
            if (opnd_wr) opnd_q <= wr_data;
            if (start) begin
                trig_q <= wr_data;
                snap_q <= opnd_q;
            end
            if (load_result) rslt_q <= unit_result;
        end
    end

    always_comb begin
        snap_opnd = snap_q;
        trig_val  = trig_q;
        unique case (slot_e'(rd_addr))
            SLOT_OPND: rd_data = opnd_q;
            SLOT_TRIG: rd_data = trig_q;
            SLOT_RSLT: rd_data = rslt_q;
            SLOT_STAT: rd_data = {{(WIDTH-2){1'b0}}, result_valid, busy};
            default:   rd_data = '0;
        endcase
    end

    AST_RSLT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_result |=> $stable(rslt_q)); // R9
    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> $stable(snap_q)); // R6
endmodule

// File: rtl/fu_socket.sv
module fu_socket #(
    parameter int WIDTH   = 16,
    parameter int LATENCY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic             busy,
    output logic             result_valid
);
    logic             start, load_result;
    logic [WIDTH-1:0] snap_opnd, trig_val, unit_result;

    fu_slots #(.WIDTH(WIDTH)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr),
        .load_result(load_result), .unit_result(unit_result),
        .busy(busy), .result_valid(result_valid),
        .start(start), .snap_opnd(snap_opnd), .trig_val(trig_val),
        .rd_data(rd_data)
    );

    fu_sequencer #(.LATENCY(LATENCY)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .result_valid(result_valid), .load_result(load_result)
    );

    fu_adder #(.WIDTH(WIDTH)) u_add (
        .a_in(snap_opnd), .b_in(trig_val), .sum_out(unit_result)
    );

    initial begin
        AST_LAT_PARAM: assert (LATENCY >= 1); // R4
    end
endmodule

// File: tb/fu_socket_test.sv
module fu_socket_test;
    localparam int W   = 16;
    localparam int LAT = 3;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         wr_en = 0;
    logic [1:0]   wr_addr = 0;
    logic [W-1:0] wr_data = 0;
    logic [1:0]   rd_addr = 0;
    logic [W-1:0] rd_data;
    logic         busy, result_valid;

    fu_socket #(.WIDTH(W), .LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .result_valid(result_valid)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    logic [W-1:0] m_op, m_trig, m_snap, m_out;
    bit m_busy, m_valid;
    int m_cnt;

    function automatic logic [W-1:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_op;
            2'd1: return m_trig;
            2'd2: return m_out;
            default: return {{(W-2){1'b0}}, m_valid, m_busy};
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_op = 0; m_trig = 0; m_snap = 0; m_out = 0;
        m_busy = 0; m_valid = 0; m_cnt = 0;
    endtask

    task automatic model_step(input bit we, input logic [1:0] wa, input logic [W-1:0] wd);
        if (we && wa == 2'd1) begin
            m_trig = wd; m_snap = m_op; m_cnt = LAT; m_busy = 1; m_valid = 0;
        end else if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_out = m_snap + m_trig; m_busy = 0; m_valid = 1;
            end
        end
        if (we && wa == 2'd0) m_op = wd;
    endtask

    task automatic cycle(input bit we, input logic [1:0] wa, input logic [W-1:0] wd,
                         input logic [1:0] ra, input string req);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        @(posedge clk);
        model_step(we, wa, wd);
        @(negedge clk);
        wr_en = 0;
        chk({req, " busy"}, W'(busy), W'(m_busy));
        chk({req, " valid"}, W'(result_valid), W'(m_valid));
        chk({req, " rd"}, rd_data, exp_rd(ra));
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #1 chk("R1 reset rd", rd_data, W'(0));
        end
        chk("R1 reset busy", W'(busy), W'(0));
        chk("R1 reset valid", W'(result_valid), W'(0));
        rst_n = 1;

        // R10: result slot zero before first completion
        cycle(1, 2'd0, 16'h1234, 2'd2, "R10");
        cycle(1, 2'd1, 16'h0101, 2'd2, "R3 R10");
        // R6: operand write right after trigger
        cycle(1, 2'd0, 16'h7777, 2'd2, "R6");
        cycle(0, 2'd0, 16'h0, 2'd2, "R4");
        cycle(0, 2'd0, 16'h0, 2'd2, "R4 R5 R6");
        chk("R5 sum", rd_data, 16'h1335);

        // R9: writes to read-only slots ignored
        cycle(1, 2'd2, 16'hDEAD, 2'd2, "R9");
        cycle(1, 2'd3, 16'hBEEF, 2'd3, "R9");
        chk("R9 stat", rd_data, 16'h0002);

        // R5 wrap
        cycle(1, 2'd0, 16'hFFFF, 2'd0, "R2");
        cycle(1, 2'd1, 16'h0002, 2'd3, "R7 R11");
        for (int i = 0; i < LAT; i++) cycle(0, 2'd0, 16'h0, 2'd2, "R4");
        chk("R5 wrap", rd_data, 16'h0001);

        // R8 restart: second trigger after one cycle
        cycle(1, 2'd0, 16'h0010, 2'd1, "R2");
        cycle(1, 2'd1, 16'h0001, 2'd3, "R8");
        cycle(1, 2'd1, 16'h0005, 2'd3, "R8");
        cycle(0, 2'd0, 16'h0, 2'd2, "R8");
        cycle(0, 2'd0, 16'h0, 2'd2, "R8");
        cycle(0, 2'd0, 16'h0, 2'd2, "R8");
        chk("R8 restart value", rd_data, 16'h0015);

        // Random stream
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 9);
            logic [1:0] wa = (r < 3) ? 2'd0 : (r < 5) ? 2'd1 : (r < 6) ? 2'(2 + (r & 1)) : 2'd0;
            cycle(r < 6, wa, W'($urandom), 2'($urandom_range(0, 3)), "R2 R4 R5 R11 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule